// File: doc/BRIEF.md
# Encoder velocity capture timer

This block estimates shaft speed by counting encoder steps over a window of fixed length. A down-counting window timer is loaded from a programmable reload value. While it runs, single-cycle step pulses from a quadrature decoder are added to a live step counter. When the timer reaches zero, the live count is stored as the captured speed, a new count begins at once, and a window-done event is pulsed. The timer then reloads for the next window.

Each captured value is compared once against a programmable speed limit. A slow event is pulsed alongside window-done whenever the capture is strictly below that limit. A software clear strobe discards the window in progress and starts a new one. The window timer, the live step count and the last captured speed can each be read at the outputs.

Top module: `enc_speed_meter`

## Requirements
- R1: While `rst_n` is low, `timer_now`, `pulse_count`, `speed_capture`, `window_done` and `slow_evt` are all 0. On the first clock edge after release, the timer loads `reload_val`. Any step sampled on that edge is dropped.
- R2: From a load, `timer_now` counts down by one each cycle until it reaches 0. It then reloads on the next edge, so each window lasts `reload_val`+1 clock edges.
- R3: `window_done` is high for exactly one cycle after the expiry edge. At that point `speed_capture` holds the number of steps sampled in the window's earlier edges, and `timer_now` equals the reload value sampled on the expiry edge.
- R4: A step sampled on the expiry edge is counted in the new window, so `pulse_count` reads 1 while `window_done` is high.
- R5: `slow_evt` pulses together with `window_done` only when the new capture is strictly less than `vel_limit` as sampled on the expiry edge. A capture equal to the limit does not raise it.
- R6: The limit comparison happens only at capture. `slow_evt` is never high without `window_done`, and changes to `vel_limit` during a window have no effect until its expiry edge.
- R7: An edge with `vel_clear` high zeroes `pulse_count` and drops any step on that edge. It also reloads the timer from `reload_val`, raises neither event, and leaves `speed_capture` unchanged.
- R8: A change of `reload_val` during a window does not shorten or lengthen that window. It applies from the next reload onward.
- R9: `pulse_count` shows the live step count of the current window, one cycle after each step is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_pulse | input | 1 | One-cycle encoder step pulse from the decoder |
| vel_clear | input | 1 | Software strobe that restarts the measurement |
| reload_val | input | TW | Window timer reload value |
| vel_limit | input | CW | Speed threshold for the slow event |
| timer_now | output | TW | Current window timer value |
| pulse_count | output | CW | Live step count of the current window |
| speed_capture | output | CW | Step count of the last completed window |
| window_done | output | 1 | One-cycle window expiry event |
| slow_evt | output | 1 | One-cycle event: capture below limit |

## Verification
The properties assume that `vel_clear` and `step_pulse` are 0 while reset is held. They also assume that each window is short enough that the step counter never wraps. The stimulus drives inputs only between edges, keeps every window to at most a handful of steps, and never raises the clear strobe during reset. The expected capture for each window is pushed by the driver, which knows how many steps it placed before the expiry edge and whether one landed on that edge. The expected slow flag is computed from the limit in force on that edge.

// File: rtl/enc_speed_pkg.sv
package enc_speed_pkg;

    // Default widths of the window timer and of the step counters
    localparam int TIMER_W_DEF = 32;
    localparam int COUNT_W_DEF = 32;

    // What the window timer does on the coming edge; every other unit keys off it
    typedef enum logic [1:0] {
        ACT_RUN    = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_EXPIRE = 2'd2,
        ACT_CLEAR  = 2'd3
    } win_act_e;

endpackage

// File: rtl/vel_window_timer.sv
module vel_window_timer
    import enc_speed_pkg::*;
#(
    parameter int TW = TIMER_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [TW-1:0] reload_i,
    output logic [TW-1:0] timer_o,
    output win_act_e      act_o
);

    localparam logic [TW-1:0] ZERO = '0;
    localparam logic [TW-1:0] ONE  = {{(TW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          armed;
    } tmr_st_t;

    tmr_st_t  st_d, st_q;
    win_act_e act_d;

    always_comb begin
        st_d  = st_q;
        act_d = ACT_RUN;
        if (clear_i) begin
            act_d      = ACT_CLEAR;
            st_d.tmr   = reload_i;
            st_d.armed = 1'b1;
        end else if (!st_q.armed) begin
            act_d      = ACT_LOAD;
            st_d.tmr   = reload_i;
            st_d.armed = 1'b1;
        end else if (st_q.tmr == ZERO) begin
            act_d    = ACT_EXPIRE;
            st_d.tmr = reload_i;
        end else begin
            st_d.tmr = st_q.tmr - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign timer_o = st_q.tmr;
    assign act_o   = act_d;

endmodule

// File: rtl/vel_pulse_accum.sv
module vel_pulse_accum
    import enc_speed_pkg::*;
#(
    parameter int CW = COUNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  win_act_e      act_i,
    input  logic          step_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] capture_o,
    output logic          done_o
);

    localparam logic [CW-1:0] ZERO = '0;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
        logic          done;
    } acc_st_t;

    acc_st_t       st_d, st_q;
    logic [CW-1:0] step_ext;

    assign step_ext = {{(CW-1){1'b0}}, step_i};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (act_i)
            ACT_CLEAR, ACT_LOAD: st_d.cnt = ZERO;
            ACT_EXPIRE: begin
                st_d.cap  = st_q.cnt;
                st_d.cnt  = step_ext;
                st_d.done = 1'b1;
            end
            default: st_d.cnt = st_q.cnt + step_ext;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o   = st_q.cnt;
    assign capture_o = st_q.cap;
    assign done_o    = st_q.done;

endmodule

// File: rtl/vel_threshold_cmp.sv
module vel_threshold_cmp
    import enc_speed_pkg::*;
#(
    parameter int CW = COUNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  win_act_e      act_i,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] limit_i,
    output logic          slow_o
);

    typedef struct packed {
        logic slow;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    // The count being captured on an expiry edge is the live count itself,
    // so the comparison runs once per window, on that edge only.
    always_comb begin
        st_d.slow = (act_i == ACT_EXPIRE) && (count_i < limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slow_o = st_q.slow;

endmodule

// File: rtl/enc_speed_meter.sv
module enc_speed_meter
    import enc_speed_pkg::*;
#(
    parameter int TW = TIMER_W_DEF,
    parameter int CW = COUNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_pulse,
    input  logic          vel_clear,
    input  logic [TW-1:0] reload_val,
    input  logic [CW-1:0] vel_limit,
    output logic [TW-1:0] timer_now,
    output logic [CW-1:0] pulse_count,
    output logic [CW-1:0] speed_capture,
    output logic          window_done,
    output logic          slow_evt
);

    win_act_e act;

    vel_window_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (vel_clear),
        .reload_i (reload_val),
        .timer_o  (timer_now),
        .act_o    (act)
    );

    vel_pulse_accum #(.CW(CW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .step_i    (step_pulse),
        .count_o   (pulse_count),
        .capture_o (speed_capture),
        .done_o    (window_done)
    );

    vel_threshold_cmp #(.CW(CW)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .count_i (pulse_count),
        .limit_i (vel_limit),
        .slow_o  (slow_evt)
    );

endmodule

// File: rtl/enc_speed_meter_chk.sv
module enc_speed_meter_chk #(
    parameter int TW = 32,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_pulse,
    input logic          vel_clear,
    input logic [TW-1:0] reload_val,
    input logic [CW-1:0] vel_limit,
    input logic [TW-1:0] timer_now,
    input logic [CW-1:0] pulse_count,
    input logic [CW-1:0] speed_capture,
    input logic          window_done,
    input logic          slow_evt
);

    // R2
    expiry_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> ($past(timer_now) == '0));

    // R3
    reload_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> (timer_now == $past(reload_val)));

    // R4
    fresh_window_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> (pulse_count == {{(CW-1){1'b0}}, $past(step_pulse)}));

    // R5
    slow_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_evt |-> (speed_capture < $past(vel_limit)));

    // R6
    slow_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_evt |-> window_done);

    // R7
    clear_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vel_clear |=> (pulse_count == '0) && !window_done && (timer_now == $past(reload_val)));

    // R3
    capture_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !window_done |-> $stable(speed_capture));

endmodule

bind enc_speed_meter enc_speed_meter_chk #(.TW(TW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_pulse    (step_pulse),
    .vel_clear     (vel_clear),
    .reload_val    (reload_val),
    .vel_limit     (vel_limit),
    .timer_now     (timer_now),
    .pulse_count   (pulse_count),
    .speed_capture (speed_capture),
    .window_done   (window_done),
    .slow_evt      (slow_evt)
);

// File: tb/tb_enc_speed_meter.sv
module tb_enc_speed_meter;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 32;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          step_pulse;
    logic          vel_clear;
    logic [TW-1:0] reload_val;
    logic [CW-1:0] vel_limit;
    logic [TW-1:0] timer_now;
    logic [CW-1:0] pulse_count;
    logic [CW-1:0] speed_capture;
    logic          window_done;
    logic          slow_evt;

    typedef struct {
        logic [CW-1:0] cap;
        logic          slow;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   carry_pend = 0;
    bit   done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_speed_meter #(.TW(TW), .CW(CW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_pulse    (step_pulse),
        .vel_clear     (vel_clear),
        .reload_val    (reload_val),
        .vel_limit     (vel_limit),
        .timer_now     (timer_now),
        .pulse_count   (pulse_count),
        .speed_capture (speed_capture),
        .window_done   (window_done),
        .slow_evt      (slow_evt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one complete window of r+1 edges with n steps at its start,
    // optionally a step on the expiry edge; pushes the expected capture.
    task automatic run_win(input int r, input int n, input bit tail,
                           input logic [CW-1:0] lim_a, input logic [CW-1:0] lim_b,
                           input logic [TW-1:0] new_rel);
        exp_t e;
        e.cap  = CW'(n + carry_pend);
        e.slow = (e.cap < lim_b);
        expq.push_back(e);
        for (int i = 0; i <= r; i++) begin
            step_pulse = (i < n) || (i == r && tail);
            vel_limit  = (i == r) ? lim_b : lim_a;
            if (i == 1) reload_val = new_rel;
            @(negedge clk);
            if (i == r - 1) begin
                check("R9 live count", pulse_count, 64'(n + carry_pend));
                check("R2 timer at zero", timer_now, 0);
            end
        end
        step_pulse = 1'b0;
        carry_pend = tail ? 1 : 0;
        check("R3 window_done", window_done, 1);
        check("R4 count after expiry", pulse_count, 64'(carry_pend));
        check("R2 reload after expiry", timer_now, 64'(reload_val));
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                if (window_done) begin
                    if (expq.size() == 0) begin
                        n_checks++; n_fails++;
                        $display("FAIL R3 unexpected window_done actual=1 expected=0");
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check("R3 capture", speed_capture, 64'(e.cap));
                        check("R5 slow_evt", slow_evt, 64'(e.slow));
                    end
                end else if (slow_evt) begin
                    check("R6 slow_evt without capture", slow_evt, 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        step_pulse = 1'b0;
        vel_clear  = 1'b0;
        reload_val = 32'd7;
        vel_limit  = 32'd4;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 timer", timer_now, 0);
        check("R1 count", pulse_count, 0);
        check("R1 capture", speed_capture, 0);
        check("R1 flags", {window_done, slow_evt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 load after reset", timer_now, 7);

        run_win(7, 5, 0, 4, 4, 7);    // R3: capture 5, not slow
        run_win(7, 3, 1, 4, 4, 7);    // R5: capture 3 < 4, step on expiry edge
        run_win(7, 3, 0, 4, 4, 7);    // R4/R5: capture 4 equal to limit, not slow
        run_win(7, 0, 0, 4, 4, 7);    // R5: empty window, slow
        run_win(7, 3, 0, 100, 2, 7);  // R6: limit changed late, 3 < 2 false
        run_win(7, 2, 0, 4, 4, 3);    // R8: reload changed mid-window
        check("R8 new reload", timer_now, 3);
        run_win(3, 3, 0, 4, 4, 3);    // R2: shorter window, capture 3

        // R7: clear mid-window with a step on the clear edge
        step_pulse = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 partial count", pulse_count, 2);
        vel_clear = 1'b1;
        @(negedge clk);
        vel_clear  = 1'b0;
        step_pulse = 1'b0;
        carry_pend = 0;
        check("R7 count cleared", pulse_count, 0);
        check("R7 timer reloaded", timer_now, 3);
        check("R7 capture kept", speed_capture, 3);
        check("R7 no event", window_done, 0);
        run_win(3, 1, 0, 4, 4, 3);    // R7: fresh window after clear
        @(negedge clk);
        check("R3 queue drained", expq.size(), 0);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule